// File: doc/BRIEF.md
# Accumulator Extract Unit

This unit turns a 64-bit accumulator into a 32-bit register value in one of two ways. In shift mode it shifts the accumulator arithmetically right by 0 to 31 places. Rounding to nearest and clamping to the signed 32-bit range are both optional, and an overflow indication is raised whenever the accumulator cannot be represented faithfully. In field mode it cuts a run of `size+1` bits out of the accumulator. The top bit of the run sits at a 6-bit position supplied by the caller. A second field mode also steps that position down past the consumed bits, so a stream of variable-width fields can be peeled off the accumulator one after another.

The block keeps no control state of its own. The caller passes in the current position and gets back the next position, a field-failure flag and an overflow flag, and writes them into whatever control register it keeps. Each accepted request produces a registered response exactly one clock later.

Top module: `acc_extract_unit`

## Requirements
- R1: While `rstN` is low and after reset, `rspValid`, `result`, `posOut`, `extFail` and `ovf` are all 0.
- R2: A request with `reqValid` high and `reqMode` 0 (shift), 1 (field) or 2 (field with decrement) gives `rspValid` high on the following clock only. A request with `reqMode` 3, or no request, gives no response and all other outputs keep their values.
- R3: In shift mode with an amount of 0, `result` is the low 32 bits of the accumulator, and no rounding is applied even when `roundEn` is set.
- R4: In shift mode with an amount from 1 to 31 and rounding off, `result` is the low 32 bits of the accumulator shifted arithmetically right by that amount.
- R5: With `roundEn` set and an amount above 0, 2^(amount-1) is added to the accumulator (64-bit wrap) before the arithmetic shift.
- R6: If the accumulator is positive and that rounding addition makes it negative, `ovf` is set. With `satEn` set, the value is replaced by the largest positive 64-bit number before the shift.
- R7: In shift mode `ovf` is also set when the unshifted accumulator lies outside [-2^31, 2^31-1]. With `satEn` set, the shifted value is then clamped to 0x7FFFFFFF or 0x80000000 when it exceeds that range and passed unchanged otherwise. Without `satEn`, its low 32 bits are returned.
- R8: In field modes with `posIn >= amount`, `result` holds accumulator bits [posIn : posIn-amount], right-aligned and zero-extended to 32 bits, and `extFail` is 0.
- R9: In field modes with `posIn < amount`, `result` is 0, `extFail` is 1 and `posOut` equals `posIn`.
- R10: In field-with-decrement mode a successful extract gives `posOut = posIn-amount-1`, and gives 63 when `posIn` equals `amount`.
- R11: Shift mode and plain field mode return `posOut = posIn`. Shift mode always returns `extFail` = 0, and both field modes always return `ovf` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqMode | input | 2 | 0 shift, 1 field, 2 field with decrement, 3 reserved |
| accIn | input | 64 | Accumulator value |
| amount | input | 5 | Shift amount (shift mode) or field size minus one (field modes) |
| roundEn | input | 1 | Round to nearest in shift mode |
| satEn | input | 1 | Clamp to signed 32-bit range in shift mode |
| posIn | input | 6 | Current position field |
| rspValid | output | 1 | Response strobe, one clock after a request |
| result | output | 32 | Extracted value |
| posOut | output | 6 | Next value of the position field |
| extFail | output | 1 | Field extract lacked enough bits |
| ovf | output | 1 | Shift-extract overflow |

## Verification
The assertions assume that the request fields are stable and meaningful only in a cycle where `reqValid` is high. They also assume that `posIn` arrives already sized to 6 bits, so every position from 0 to 63 is legal. The bench changes inputs only on the falling clock edge and lowers `reqValid` after each single-cycle request. Every position and size it applies lies inside the declared port widths, so each rule is checked at its boundary values: a position equal to the size, size 31 at position 63, and a rounding carry into the sign bit.

// File: rtl/xtr_pkg.sv
package xtr_pkg;

  // Request kinds carried on reqMode.
  typedef enum logic [1:0] {
    MODE_SHIFT     = 2'd0,
    MODE_FIELD     = 2'd1,
    MODE_FIELD_DEC = 2'd2,
    MODE_NONE      = 2'd3
  } xtrMode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadShift;
    logic loadField;
    logic decPos;
  } xtrStrobe_t;

endpackage

// File: rtl/xtr_ctrl.sv
module xtr_ctrl
  import xtr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqMode,
  output xtrStrobe_t strobe,
  output logic       rspValid
);

  xtrMode_e mode;
  assign mode = xtrMode_e'(reqMode);

  always_comb begin
    strobe = '0;
    if (reqValid) begin
      case (mode)
        MODE_SHIFT:     strobe.loadShift = 1'b1;
        MODE_FIELD:     strobe.loadField = 1'b1;
        MODE_FIELD_DEC: begin
          strobe.loadField = 1'b1;
          strobe.decPos    = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= strobe.loadShift | strobe.loadField;
  end

  // A legal request is answered on the next clock.
  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode != 2'd3) |=> rspValid);

  // Reserved mode and idle cycles produce no response.
  assert_no_rsp_when_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid || reqMode == 2'd3) |=> !rspValid);

endmodule

// File: rtl/xtr_datapath.sv
module xtr_datapath
  import xtr_pkg::*;
#(
  parameter int ACC_W = 64,
  parameter int RES_W = 32,
  parameter int SH_W  = 5,
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  xtrStrobe_t       strobe,
  input  logic [ACC_W-1:0] accIn,
  input  logic [SH_W-1:0]  amount,
  input  logic             roundEn,
  input  logic             satEn,
  input  logic [POS_W-1:0] posIn,
  output logic [RES_W-1:0] result,
  output logic [POS_W-1:0] posOut,
  output logic             extFail,
  output logic             ovf
);

  localparam logic [ACC_W-1:0] ACC_SMAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] RES_SMAX = {{(ACC_W-RES_W+1){1'b0}}, {(RES_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] RES_SMIN = {{(ACC_W-RES_W+1){1'b1}}, {(RES_W-1){1'b0}}};
  localparam int               HIGH_W   = ACC_W - RES_W + 1;

  // ---------------- shift-extract path ----------------
  logic                    shiftNonZero;
  logic [ACC_W-1:0]        halfLsb;
  logic [ACC_W-1:0]        roundSum;
  logic                    roundOvf;
  logic                    rangeOvf;
  logic signed [ACC_W-1:0] preShift;
  logic signed [ACC_W-1:0] shifted;
  logic [RES_W-1:0]        shiftRes;
  logic                    shiftOvf;
  logic [HIGH_W-1:0]       accHigh;

  assign shiftNonZero = (amount != '0);
  assign halfLsb      = shiftNonZero ? (ACC_W'(1) << (amount - SH_W'(1))) : '0;
  assign roundSum     = accIn + halfLsb;
  assign accHigh      = accIn[ACC_W-1:RES_W-1];

  always_comb begin
    roundOvf = roundEn && shiftNonZero && !accIn[ACC_W-1] && (accIn != '0)
               && roundSum[ACC_W-1];
    rangeOvf = !((accHigh == '0) || (accHigh == '1));
    shiftOvf = roundOvf || rangeOvf;

    if (!shiftNonZero)               preShift = accIn;
    else if (!roundEn)               preShift = accIn;
    else if (roundOvf && satEn)      preShift = ACC_SMAX;
    else                             preShift = roundSum;

    shifted = preShift >>> amount;

    if (shiftOvf && satEn) begin
      if (shifted > $signed(RES_SMAX))      shiftRes = RES_SMAX[RES_W-1:0];
      else if (shifted < $signed(RES_SMIN)) shiftRes = RES_SMIN[RES_W-1:0];
      else                                  shiftRes = shifted[RES_W-1:0];
    end else begin
      shiftRes = shifted[RES_W-1:0];
    end
  end

  // ---------------- bit-field path ----------------
  logic             fieldFail;
  logic [POS_W-1:0] fieldLow;
  logic [RES_W-1:0] fieldWin;
  logic [RES_W-1:0] fieldMask;
  logic [RES_W-1:0] fieldRes;
  logic [POS_W-1:0] fieldNextPos;

  always_comb begin
    fieldFail    = posIn < POS_W'(amount);
    fieldLow     = posIn - POS_W'(amount);
    fieldWin     = RES_W'(accIn >> fieldLow);
    fieldMask    = {RES_W{1'b1}} >> (SH_W'(RES_W - 1) - amount);
    fieldRes     = fieldFail ? '0 : (fieldWin & fieldMask);
    // Modulo-2^POS_W subtraction turns -1 into the top position.
    fieldNextPos = posIn - POS_W'(amount) - POS_W'(1);
  end

  // ---------------- output registers ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      result  <= '0;
      posOut  <= '0;
      extFail <= 1'b0;
      ovf     <= 1'b0;
    end else if (strobe.loadShift) begin
      result  <= shiftRes;
      posOut  <= posIn;
      extFail <= 1'b0;
      ovf     <= shiftOvf;
    end else if (strobe.loadField) begin
      result  <= fieldRes;
      posOut  <= (strobe.decPos && !fieldFail) ? fieldNextPos : posIn;
      extFail <= fieldFail;
      ovf     <= 1'b0;
    end
  end

  // Rounding carry into the sign of the largest accumulator clamps high.
  assert_round_carry_clamps_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadShift && roundEn && satEn && amount != '0 && accIn == ACC_SMAX)
    |=> (ovf && result == RES_SMAX[RES_W-1:0]));

  // A field of width one at position zero yields the lowest accumulator bit.
  assert_single_bit_field_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadField && amount == '0 && posIn == '0)
    |=> (result == RES_W'($past(accIn[0])) && !extFail));

  // Exact consumption in decrement mode wraps the position to the top.
  assert_dec_wrap_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.decPos && posIn == POS_W'(amount)) |=> (posOut == '1));

endmodule

// File: rtl/acc_extract_unit.sv
module acc_extract_unit
  import xtr_pkg::*;
#(
  parameter int ACC_W = 64,
  parameter int RES_W = 32,
  localparam int SH_W  = $clog2(RES_W),
  localparam int POS_W = $clog2(ACC_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqMode,
  input  logic [ACC_W-1:0] accIn,
  input  logic [SH_W-1:0]  amount,
  input  logic             roundEn,
  input  logic             satEn,
  input  logic [POS_W-1:0] posIn,
  output logic             rspValid,
  output logic [RES_W-1:0] result,
  output logic [POS_W-1:0] posOut,
  output logic             extFail,
  output logic             ovf
);

  xtrStrobe_t strobe;

  xtr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqMode  (reqMode),
    .strobe   (strobe),
    .rspValid (rspValid)
  );

  xtr_datapath #(
    .ACC_W (ACC_W),
    .RES_W (RES_W),
    .SH_W  (SH_W),
    .POS_W (POS_W)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .accIn   (accIn),
    .amount  (amount),
    .roundEn (roundEn),
    .satEn   (satEn),
    .posIn   (posIn),
    .result  (result),
    .posOut  (posOut),
    .extFail (extFail),
    .ovf     (ovf)
  );

  // A failed field returns zero and never reports overflow.
  assert_fail_result_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && extFail) |-> (result == '0 && !ovf));

  // A field lacking bits keeps the position.
  assert_fail_keeps_pos_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqMode == 2'd1 || reqMode == 2'd2) && posIn < POS_W'(amount))
    |=> (extFail && posOut == $past(posIn)));

  // Shift mode passes the position through and never flags a field failure.
  assert_shift_keeps_pos_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode == 2'd0) |=> (posOut == $past(posIn) && !extFail));

  // Field modes never raise overflow.
  assert_field_no_ovf_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqMode == 2'd1 || reqMode == 2'd2)) |=> !ovf);

  // Without a legal request the outputs hold.
  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid || reqMode == 2'd3)
    |=> ($stable(result) && $stable(posOut) && $stable(extFail) && $stable(ovf)));

endmodule

// File: tb/test_acc_extract_unit.sv
`timescale 1ns/1ps
module test_acc_extract_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [1:0]  reqMode;
  logic [63:0] accIn;
  logic [4:0]  amount;
  logic        roundEn;
  logic        satEn;
  logic [5:0]  posIn;
  logic        rspValid;
  logic [31:0] result;
  logic [5:0]  posOut;
  logic        extFail;
  logic        ovf;

  int checks   = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  acc_extract_unit i_acc_extract_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .accIn(accIn), .amount(amount), .roundEn(roundEn), .satEn(satEn),
    .posIn(posIn), .rspValid(rspValid), .result(result), .posOut(posOut),
    .extFail(extFail), .ovf(ovf)
  );

  typedef struct packed {
    logic [15:0] tag;
    logic [1:0]  mode;
    logic [63:0] acc;
    logic [4:0]  amt;
    logic        rnd;
    logic        sat;
    logic [5:0]  pos;
    logic [31:0] eRes;
    logic [5:0]  ePos;
    logic        eFail;
    logic        eOvf;
  } vec_t;

  localparam int NV = 20;
  localparam logic [63:0] ACC_F = 64'h0123_4567_89AB_CDEF;
  localparam vec_t VECS [NV] = '{
    '{"R3", 2'd0, 64'h0000_0000_1234_5678, 5'd0,  1'b1, 1'b1, 6'd5,  32'h1234_5678, 6'd5,  1'b0, 1'b0},
    '{"R3", 2'd0, 64'h0000_0001_0000_0005, 5'd0,  1'b0, 1'b0, 6'd7,  32'h0000_0005, 6'd7,  1'b0, 1'b1},
    '{"R4", 2'd0, 64'hFFFF_FFFF_FFFF_FF00, 5'd4,  1'b0, 1'b0, 6'd1,  32'hFFFF_FFF0, 6'd1,  1'b0, 1'b0},
    '{"R4", 2'd0, 64'h0000_0000_7000_0000, 5'd28, 1'b0, 1'b1, 6'd2,  32'h0000_0007, 6'd2,  1'b0, 1'b0},
    '{"R5", 2'd0, 64'h0000_0000_0000_0017, 5'd3,  1'b1, 1'b0, 6'd3,  32'h0000_0003, 6'd3,  1'b0, 1'b0},
    '{"R5", 2'd0, 64'hFFFF_FFFF_FFFF_FFEB, 5'd2,  1'b1, 1'b0, 6'd4,  32'hFFFF_FFFB, 6'd4,  1'b0, 1'b0},
    '{"R6", 2'd0, 64'h7FFF_FFFF_FFFF_FFFF, 5'd1,  1'b1, 1'b1, 6'd8,  32'h7FFF_FFFF, 6'd8,  1'b0, 1'b1},
    '{"R6", 2'd0, 64'h7FFF_FFFF_FFFF_FFFF, 5'd1,  1'b1, 1'b0, 6'd9,  32'h0000_0000, 6'd9,  1'b0, 1'b1},
    '{"R7", 2'd0, 64'h0000_0100_0000_0000, 5'd4,  1'b0, 1'b1, 6'd10, 32'h7FFF_FFFF, 6'd10, 1'b0, 1'b1},
    '{"R7", 2'd0, 64'h0000_0100_0000_0000, 5'd4,  1'b0, 1'b0, 6'd11, 32'h0000_0000, 6'd11, 1'b0, 1'b1},
    '{"R7", 2'd0, 64'hFFFF_FF00_0000_0000, 5'd4,  1'b0, 1'b1, 6'd12, 32'h8000_0000, 6'd12, 1'b0, 1'b1},
    '{"R7", 2'd0, 64'h0000_0100_0000_0000, 5'd20, 1'b0, 1'b1, 6'd13, 32'h0010_0000, 6'd13, 1'b0, 1'b1},
    '{"R8", 2'd1, ACC_F,                   5'd7,  1'b1, 1'b1, 6'd15, 32'h0000_00CD, 6'd15, 1'b0, 1'b0},
    '{"R8", 2'd1, ACC_F,                   5'd31, 1'b0, 1'b0, 6'd63, 32'h0123_4567, 6'd63, 1'b0, 1'b0},
    '{"R8", 2'd1, ACC_F,                   5'd0,  1'b0, 1'b0, 6'd0,  32'h0000_0001, 6'd0,  1'b0, 1'b0},
    '{"R9", 2'd1, ACC_F,                   5'd10, 1'b0, 1'b0, 6'd9,  32'h0000_0000, 6'd9,  1'b1, 1'b0},
    '{"R10",2'd2, ACC_F,                   5'd3,  1'b0, 1'b0, 6'd20, 32'h0000_0005, 6'd16, 1'b0, 1'b0},
    '{"R10",2'd2, ACC_F,                   5'd5,  1'b0, 1'b0, 6'd5,  32'h0000_002F, 6'd63, 1'b0, 1'b0},
    '{"R9", 2'd2, ACC_F,                   5'd6,  1'b0, 1'b0, 6'd5,  32'h0000_0000, 6'd5,  1'b1, 1'b0},
    '{"R10",2'd2, ACC_F,                   5'd31, 1'b0, 1'b0, 6'd63, 32'h0123_4567, 6'd31, 1'b0, 1'b0}
  };

  task automatic check(input logic [15:0] tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic checkAll(input logic [15:0] tag, input logic eValid,
                          input logic [31:0] eRes, input logic [5:0] ePos,
                          input logic eFail, input logic eOvf);
    check(tag, "rspValid", 64'(rspValid), 64'(eValid));
    check(tag, "result",   64'(result),   64'(eRes));
    check(tag, "posOut",   64'(posOut),   64'(ePos));
    check(tag, "extFail",  64'(extFail),  64'(eFail));
    check(tag, "ovf",      64'(ovf),      64'(eOvf));
  endtask

  initial begin
    #(5.0 * 100000);
    failures++;
    $display("FAIL R2 watchdog actual=hang expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset holds everything at zero even with a request applied.
    rstN = 1'b0; reqValid = 1'b1; reqMode = 2'd0; accIn = 64'h1234;
    amount = 5'd0; roundEn = 1'b0; satEn = 1'b0; posIn = 6'd17;
    repeat (3) @(negedge clk);
    checkAll("R1", 1'b0, 32'h0, 6'd0, 1'b0, 1'b0);
    reqValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1", 1'b0, 32'h0, 6'd0, 1'b0, 1'b0);

    // Table walk: one request per vector, sampled one clock later.
    for (int i = 0; i < NV; i++) begin
      reqValid = 1'b1;
      reqMode  = VECS[i].mode;
      accIn    = VECS[i].acc;
      amount   = VECS[i].amt;
      roundEn  = VECS[i].rnd;
      satEn    = VECS[i].sat;
      posIn    = VECS[i].pos;
      @(negedge clk);
      reqValid = 1'b0;
      checkAll(VECS[i].tag, 1'b1, VECS[i].eRes, VECS[i].ePos,
               VECS[i].eFail, VECS[i].eOvf);
    end

    // R2: response lasts one clock, outputs hold while idle.
    accIn = 64'hFFFF_0000_FFFF_0000; posIn = 6'd33; amount = 5'd1;
    @(negedge clk);
    checkAll("R2", 1'b0, VECS[NV-1].eRes, VECS[NV-1].ePos,
             VECS[NV-1].eFail, VECS[NV-1].eOvf);

    // R2: reserved mode is ignored.
    reqValid = 1'b1; reqMode = 2'd3; accIn = 64'h0000_0000_0000_00AA;
    amount = 5'd0; posIn = 6'd2;
    @(negedge clk);
    reqValid = 1'b0;
    checkAll("R2", 1'b0, VECS[NV-1].eRes, VECS[NV-1].ePos,
             VECS[NV-1].eFail, VECS[NV-1].eOvf);

    // R11: shift right after a decrement still echoes the given position.
    reqValid = 1'b1; reqMode = 2'd0; accIn = 64'h0000_0000_0000_0040;
    amount = 5'd6; roundEn = 1'b0; satEn = 1'b0; posIn = 6'd44;
    @(negedge clk);
    reqValid = 1'b0;
    checkAll("R11", 1'b1, 32'h1, 6'd44, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule